// File: doc/BRIEF.md
# Masked Stream Pattern Verifier

This block drains a circular receive byte buffer and checks the drained bytes against a generated reference sequence. The buffer is 16 KB by default. A producer writes bytes into the buffer and moves its write pointer forward. The verifier reads one 16-byte word per cycle once enough bytes are present, and moves its own read pointer past the bytes it used, which frees that space for the producer.

Each run is programmed when it starts, and the stream it consumes has three parts in order:
- a header byte count, dropped unchecked;
- a payload length, compared against one of four reference sequences;
- a trailer byte count, dropped unchecked.

A per-byte mask limits each comparison to the payload bytes of the current word, so runs may begin and end at any byte lane. The first word that mismatches raises a sticky error flag. Its raw buffer word and its masked reference word are frozen for software to inspect.

The read pointer carries over from one run to the next. A run made only of header bytes therefore moves the pointer to any wanted byte position.

Top module: `stream_pattern_verifier`

## Requirements
- R1: After reset, busy_o, err_o and rd_en_o are 0, and rd_ptr_o, remain_len_o, act_word_o and exp_word_o are all zero.
- R2: A start_i pulse while idle latches the mode, the payload length, the header length and the trailer length. busy_o then stays 1 until all header+payload+trailer bytes have been read and the last comparison is done. A start_i pulse while busy_o=1 has no effect.
- R3: Buffer byte address a lives in word a[13:4] at bits [8*a[3:0]+7 : 8*a[3:0]]. rd_addr_o gives the word index while rd_en_o=1, and rd_data_i carries that word one cycle later.
- R4: A word is read only when (wr_ptr_i - rd_ptr_o) mod 16384 is at least the number of stream bytes the run still needs from that word. With no bytes present, rd_en_o stays 0 and rd_ptr_o does not move.
- R5: Each read advances rd_ptr_o by the number of stream bytes taken from that word. After a run, rd_ptr_o equals the start pointer plus header+payload+trailer, modulo 16384.
- R6: Payload byte k (counted from 0) is expected to be as follows, by mode_i:
  - 00: 0xFF-(k mod 256)
  - 01: k mod 256
  - 10: the upper-case ASCII hex digit of 15-(k mod 16)
  - 11: the ASCII hex digit of k mod 16
- R7: Header and trailer bytes are never compared; any value there leaves err_o at 0.
- R8: The reference word is zero outside the payload bytes of the current word. From start pointer 0x1F in mode 00, the first word is exp 0xFF in bits [127:120] and zero elsewhere. For a 451-byte run in mode 01 ending at lane 1, the last word is 0xC2C1 in bits [15:0] and zero elsewhere.
- R9: remain_len_o is loaded with the payload length at start, drops by the number of payload bytes in each compared word, and is 0 when the run ends.
- R10: The first compared word with a masked byte difference sets err_o. That same comparison captures rd_data_i into act_word_o and the reference word into exp_word_o. Later mismatches change neither until the next accepted start, which clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (ignored while busy) |
| mode_i | input | 2 | Reference sequence select |
| verify_len_i | input | 32 | Payload byte count |
| header_len_i | input | 14 | Bytes skipped before the payload |
| trailer_len_i | input | 14 | Bytes skipped after the payload |
| wr_ptr_i | input | 14 | Producer write pointer (byte) |
| rd_data_i | input | 128 | Buffer word, one cycle after rd_en_o |
| rd_addr_o | output | 10 | Buffer word index to read |
| rd_en_o | output | 1 | Read strobe |
| rd_ptr_o | output | 14 | Consumer read pointer (byte) |
| busy_o | output | 1 | Run in progress |
| remain_len_o | output | 32 | Payload bytes not yet compared |
| err_o | output | 1 | Mismatch seen in this run |
| act_word_o | output | 128 | Buffer word of the first mismatch |
| exp_word_o | output | 128 | Masked reference word of the first mismatch |

## Verification
Directed runs place the read pointer at lane 15 and at a lane that makes a 451-byte run end on lane 1. Injected errors in those first and last bytes then expose the masking and the reference value at both word edges.

A long run with two corrupted payload bytes and a start pulse in the middle tells first-error capture apart from later overwrites, and an accepted restart apart from an ignored one. A run with random header and trailer bytes separates skipped bytes from compared ones.

Random runs vary all four modes, the three lengths, the start lane and the producer's pace. Their final pointer, remaining count, flag and captured words are compared with a byte-level model in the bench.

// File: rtl/spv_pkg.sv
package spv_pkg;
  typedef enum logic [1:0] {
    PAT_DEC_BIN = 2'b00,
    PAT_INC_BIN = 2'b01,
    PAT_DEC_TXT = 2'b10,
    PAT_INC_TXT = 2'b11
  } pat_mode_e;

  function automatic logic [7:0] hex_char(input logic [3:0] v);
    return (v < 4'd10) ? (8'h30 + {4'h0, v}) : (8'h37 + {4'h0, v});
  endfunction

  function automatic logic [7:0] pat_byte(input pat_mode_e m, input logic [7:0] k);
    case (m)
      PAT_DEC_BIN: return ~k;
      PAT_INC_BIN: return k;
      PAT_DEC_TXT: return hex_char(~k[3:0]);
      default:     return hex_char(k[3:0]);
    endcase
  endfunction
endpackage

// File: rtl/spv_word_gen.sv
// Per-lane payload mask and reference bytes for the word at the read pointer.
module spv_word_gen
  import spv_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned LEN_W  = 32,
  parameter int unsigned LANE_W = $clog2(LANES),
  parameter int unsigned CNT_W  = LEN_W + 1,
  parameter int unsigned D_W    = CNT_W + 1,
  parameter int unsigned DATA_W = 8 * LANES
) (
  input  pat_mode_e          mode_i,
  input  logic [LANE_W-1:0]  lo_i,    // first lane taken
  input  logic [LANE_W:0]    n_i,     // bytes taken from this word
  input  logic [D_W-1:0]     base_i,  // stream offset minus header, two's complement
  input  logic [LEN_W-1:0]   len_i,
  output logic [DATA_W-1:0]  mask_o,
  output logic [DATA_W-1:0]  exp_o,
  output logic [LANE_W:0]    cnt_o
);
  logic [LANES-1:0] pay;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W:0] j;
    logic            take;
    logic [D_W-1:0]  pos;
    assign j    = (LANE_W+1)'(i) - {1'b0, lo_i};
    assign take = ((LANE_W+1)'(i) >= {1'b0, lo_i}) && (j < n_i);
    assign pos  = base_i + D_W'(j);
    assign pay[i] = take && !pos[D_W-1] && (pos[D_W-2:0] < CNT_W'(len_i));
    assign mask_o[8*i +: 8] = {8{pay[i]}};
    assign exp_o[8*i +: 8]  = pay[i] ? pat_byte(mode_i, pos[7:0]) : 8'h00;
  end

  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < LANES; k++) cnt_o += (LANE_W+1)'(pay[k]);
  end
endmodule

// File: rtl/spv_check.sv
// Compare stage: one cycle after the read, plus sticky capture.
module spv_check #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned LANE_W = 4,
  parameter int unsigned LEN_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              issue_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [LANE_W:0]   cnt_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              pend_o,
  output logic [LEN_W-1:0]  rem_o,
  output logic              err_o,
  output logic [DATA_W-1:0] act_o,
  output logic [DATA_W-1:0] exp_o
);
  logic              v_q;
  logic [DATA_W-1:0] mask_q, exp_q;
  logic [LANE_W:0]   cnt_q;
  logic              mism;

  assign mism   = |((rd_data_i ^ exp_q) & mask_q);
  assign pend_o = v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      mask_q <= '0;
      exp_q  <= '0;
      cnt_q  <= '0;
      rem_o  <= '0;
      err_o  <= 1'b0;
      act_o  <= '0;
      exp_o  <= '0;
    end else if (start_i) begin
      v_q   <= 1'b0;
      rem_o <= len_i;
      err_o <= 1'b0;
      act_o <= '0;
      exp_o <= '0;
    end else begin
      v_q <= issue_i;
      if (issue_i) begin
        mask_q <= mask_i;
        exp_q  <= exp_i;
        cnt_q  <= cnt_i;
      end
      if (v_q) begin
        rem_o <= rem_o - LEN_W'(cnt_q);
        if (mism && !err_o) begin
          err_o <= 1'b1;
          act_o <= rd_data_i;
          exp_o <= exp_q;
        end
      end
    end
  end
endmodule

// File: rtl/stream_pattern_verifier.sv
module stream_pattern_verifier
  import spv_pkg::*;
#(
  parameter int unsigned PTR_W = 14,
  parameter int unsigned LANES = 16,
  parameter int unsigned LEN_W = 32,
  parameter int unsigned HDR_W = 14
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [1:0]                 mode_i,
  input  logic [LEN_W-1:0]           verify_len_i,
  input  logic [HDR_W-1:0]           header_len_i,
  input  logic [HDR_W-1:0]           trailer_len_i,
  input  logic [PTR_W-1:0]           wr_ptr_i,
  input  logic [8*LANES-1:0]         rd_data_i,
  output logic [PTR_W-$clog2(LANES)-1:0] rd_addr_o,
  output logic                       rd_en_o,
  output logic [PTR_W-1:0]           rd_ptr_o,
  output logic                       busy_o,
  output logic [LEN_W-1:0]           remain_len_o,
  output logic                       err_o,
  output logic [8*LANES-1:0]         act_word_o,
  output logic [8*LANES-1:0]         exp_word_o
);
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned DATA_W = 8 * LANES;
  localparam int unsigned CNT_W  = LEN_W + 1;
  localparam int unsigned D_W    = CNT_W + 1;

  logic              busy_q;
  pat_mode_e         mode_q;
  logic [LEN_W-1:0]  len_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [CNT_W-1:0]  tot_q, c_q;
  logic [PTR_W-1:0]  rp_q;

  logic [LANE_W-1:0] lo;
  logic [LANE_W:0]   room, n;
  logic [CNT_W-1:0]  left;
  logic [PTR_W-1:0]  avail;
  logic [D_W-1:0]    base;
  logic              all_issued, issue, start_ok, pend;
  logic [DATA_W-1:0] mask_w, exp_w;
  logic [LANE_W:0]   cnt_w;

  assign start_ok   = start_i && !busy_q;
  assign lo         = rp_q[LANE_W-1:0];
  assign room       = (LANE_W+1)'(LANES) - {1'b0, lo};
  assign left       = tot_q - c_q;
  assign n          = (left < CNT_W'(room)) ? left[LANE_W:0] : room;
  assign avail      = wr_ptr_i - rp_q;
  assign all_issued = (c_q == tot_q);
  assign issue      = busy_q && !all_issued && (avail >= PTR_W'(n));
  assign base       = {1'b0, c_q} - D_W'(hdr_q);

  spv_word_gen #(.LANES(LANES), .LEN_W(LEN_W)) gen_i (
    .mode_i (mode_q),
    .lo_i   (lo),
    .n_i    (n),
    .base_i (base),
    .len_i  (len_q),
    .mask_o (mask_w),
    .exp_o  (exp_w),
    .cnt_o  (cnt_w)
  );

  spv_check #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LEN_W(LEN_W)) chk_stage_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_ok),
    .len_i     (verify_len_i),
    .issue_i   (issue),
    .mask_i    (mask_w),
    .exp_i     (exp_w),
    .cnt_i     (cnt_w),
    .rd_data_i (rd_data_i),
    .pend_o    (pend),
    .rem_o     (remain_len_o),
    .err_o     (err_o),
    .act_o     (act_word_o),
    .exp_o     (exp_word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mode_q <= PAT_DEC_BIN;
      len_q  <= '0;
      hdr_q  <= '0;
      tot_q  <= '0;
      c_q    <= '0;
      rp_q   <= '0;
    end else if (start_ok) begin
      busy_q <= 1'b1;
      mode_q <= pat_mode_e'(mode_i);
      len_q  <= verify_len_i;
      hdr_q  <= header_len_i;
      tot_q  <= CNT_W'(verify_len_i) + CNT_W'(header_len_i) + CNT_W'(trailer_len_i);
      c_q    <= '0;
    end else if (issue) begin
      c_q  <= c_q + CNT_W'(n);
      rp_q <= rp_q + PTR_W'(n);
    end else if (busy_q && all_issued && !pend) begin
      busy_q <= 1'b0;
    end
  end

  assign rd_addr_o = rp_q[PTR_W-1:LANE_W];
  assign rd_en_o   = issue;
  assign rd_ptr_o  = rp_q;
  assign busy_o    = busy_q;
endmodule

// File: rtl/spv_chk.sv
module spv_chk #(
  parameter int unsigned PTR_W  = 14,
  parameter int unsigned LEN_W  = 32,
  parameter int unsigned DATA_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [PTR_W-1:0]  wr_ptr_i,
  input logic              rd_en,
  input logic [PTR_W-1:0]  rd_ptr,
  input logic              busy,
  input logic [LEN_W-1:0]  remain,
  input logic              err,
  input logic [DATA_W-1:0] act_word,
  input logic [DATA_W-1:0] exp_word
);
  // R2
  read_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |-> busy);

  // R4
  data_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |-> (wr_ptr_i != rd_ptr));

  // R5
  ptr_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> (rd_ptr != $past(rd_ptr)));

  // R5
  ptr_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(rd_ptr));

  // R9
  remain_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !start_i) |=> (remain <= $past(remain)));

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err && !start_i) |=> err);

  // R10
  capture_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err && !start_i) |=> ($stable(act_word) && $stable(exp_word)));
endmodule

bind stream_pattern_verifier spv_chk #(.PTR_W(PTR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) sva_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .wr_ptr_i (wr_ptr_i),
  .rd_en    (rd_en_o),
  .rd_ptr   (rd_ptr_o),
  .busy     (busy_o),
  .remain   (remain_len_o),
  .err      (err_o),
  .act_word (act_word_o),
  .exp_word (exp_word_o)
);

// File: tb/stream_pattern_verifier_tb_top.sv
module stream_pattern_verifier_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [31:0]  vlen = '0;
  logic [13:0]  hlen = '0, tlen = '0;
  logic [13:0]  wp = '0;
  logic [127:0] rdq = '0;
  logic [9:0]   rd_addr;
  logic         rd_en, busy, err;
  logic [13:0]  rd_ptr;
  logic [31:0]  remain;
  logic [127:0] act_w, exp_w;

  logic [127:0] mem [1024];
  logic [13:0]  rp_m = '0;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  always @(posedge clk) rdq <= mem[rd_addr];

  stream_pattern_verifier dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .verify_len_i(vlen), .header_len_i(hlen), .trailer_len_i(tlen),
    .wr_ptr_i(wp), .rd_data_i(rdq), .rd_addr_o(rd_addr), .rd_en_o(rd_en),
    .rd_ptr_o(rd_ptr), .busy_o(busy), .remain_len_o(remain), .err_o(err),
    .act_word_o(act_w), .exp_word_o(exp_w)
  );

  function automatic logic [7:0] ref_byte(input logic [1:0] m, input int k);
    logic [7:0] v;
    logic [3:0] h;
    v = k[7:0];
    if (!m[0]) v = 8'hFF - v;
    if (m[1]) begin
      h = v[3:0];
      return (h < 4'd10) ? 8'h30 + {4'h0, h} : 8'h41 + {4'h0, h} - 8'd10;
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] a, input logic [127:0] e);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    mem[wp[13:4]][8*wp[3:0] +: 8] = b;
    wp = wp + 14'd1;
  endtask

  task automatic start_run(input logic [1:0] m, input int l, input int h, input int t);
    @(negedge clk);
    mode = m; vlen = 32'(l); hlen = 14'(h); tlen = 14'(t); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int cnt = 0;
    while (busy && cnt < 20000) begin
      @(negedge clk);
      cnt++;
    end
    chk(!busy, "R2 run did not finish", 128'(busy), 128'(0));
  endtask

  task automatic run_stream(input logic [1:0] m, input int l, input int h, input int t, input int ep);
    int tot;
    logic [13:0] sa, ea, a;
    logic [9:0] w;
    logic [127:0] ee, ea_word;
    logic [7:0] b;
    int s;
    bit want_err;
    tot = l + h + t;
    sa = rp_m;
    start_run(m, l, h, t);
    for (int p = 0; p < tot; p++) begin
      if (p >= h && p < h + l) begin
        b = ref_byte(m, p - h);
        if (p - h == ep) b = b ^ 8'h5A;
      end else b = 8'($urandom);
      put_byte(b);
      if (($urandom % 8) == 0) repeat ($urandom % 4) @(negedge clk);
    end
    wait_idle();
    repeat (2) @(negedge clk);
    want_err = (ep >= 0) && (ep < l);
    ea = sa + 14'(tot);
    chk(rd_ptr == ea, "R5 final read pointer", 128'(rd_ptr), 128'(ea));
    chk(remain == 0, "R9 remaining at end", 128'(remain), 128'(0));
    chk(err == want_err, (h + t > 0) ? "R7 error flag (skip bytes present)" : "R6 error flag",
        128'(err), 128'(want_err));
    if (want_err) begin
      a = sa + 14'(h + ep);
      w = a[13:4];
      ee = '0;
      for (int ln = 0; ln < 16; ln++) begin
        s = int'(14'({w, 4'(ln)} - sa));
        if (s >= h && s < h + l) ee[8*ln +: 8] = ref_byte(m, s - h);
      end
      ea_word = mem[w];
      chk(exp_w == ee, "R6 captured reference word", exp_w, ee);
      chk(act_w == ea_word, "R3 captured buffer word", act_w, ea_word);
    end
    rp_m = ea;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2741));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !err && !rd_en, "R1 reset flags", {busy, err, rd_en}, 128'(0));
    chk(rd_ptr == 0 && remain == 0, "R1 reset pointer/remaining", {rd_ptr, remain}, 128'(0));
    chk(act_w == 0 && exp_w == 0, "R1 reset captures", act_w | exp_w, 128'(0));

    // position at 0x1F using a header-only run
    run_stream(2'b01, 0, 31, 0, -1);
    chk(rd_ptr == 14'h01F, "R5 positioning run", 128'(rd_ptr), 128'h1F);

    // Run A: mode 00, 451 bytes, wrong first byte
    start_run(2'b00, 451, 0, 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R2 busy during run", 128'(busy), 128'(1));
    chk(!rd_en && rd_ptr == 14'h01F, "R4 no read without data", {rd_en, rd_ptr}, 128'h1F);
    put_byte(8'h00);
    repeat (4) @(negedge clk);
    chk(err == 1'b1, "R10 first mismatch flagged", 128'(err), 128'(1));
    chk(exp_w == {8'hFF, 120'h0}, "R8 first word masked reference", exp_w, {8'hFF, 120'h0});
    chk(act_w == mem[1], "R3 first word buffer capture", act_w, mem[1]);
    chk(remain == 32'd450, "R9 remaining after first word", 128'(remain), 128'd450);
    chk(rd_ptr == 14'h020, "R5 pointer after first word", 128'(rd_ptr), 128'h20);
    for (int k = 1; k < 451; k++) begin
      put_byte(ref_byte(2'b00, k) ^ ((k == 100) ? 8'h3C : 8'h00));
      if (k == 200) start_run(2'b01, 5, 0, 0);
      if (($urandom % 16) == 0) @(negedge clk);
    end
    wait_idle();
    repeat (2) @(negedge clk);
    chk(err == 1'b1, "R2 start while busy ignored (flag kept)", 128'(err), 128'(1));
    chk(exp_w == {8'hFF, 120'h0}, "R10 capture frozen after later mismatch", exp_w, {8'hFF, 120'h0});
    chk(remain == 0, "R9 remaining zero at end", 128'(remain), 128'(0));
    chk(rd_ptr == 14'h1E2, "R2 ignored start kept original length", 128'(rd_ptr), 128'h1E2);
    rp_m = 14'h1E2;

    // position at 0x41F, then Run B: mode 01, 451 bytes, wrong last byte
    run_stream(2'b01, 0, 573, 0, -1);
    run_stream(2'b01, 451, 0, 0, 450);
    chk(exp_w == 128'hC2C1, "R8 last word masked reference", exp_w, 128'hC2C1);

    // R10 restart clears flag; R7 skip bytes carry random values
    run_stream(2'b11, 40, 5, 7, -1);
    chk(err == 1'b0, "R10 flag cleared by next start", 128'(err), 128'(0));
    run_stream(2'b10, 33, 0, 0, 0);

    for (int it = 0; it < 30; it++) begin
      int l, h, t, ep;
      l  = int'($urandom % 300);
      h  = int'($urandom % 41);
      t  = int'($urandom % 41);
      ep = (($urandom % 2) == 0 || l == 0) ? -1 : int'($urandom % l);
      run_stream(2'($urandom), l, h, t, ep);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule